// File: doc/BRIEF.md
# Binary-Tree Parallel-to-Serial Converter

This block turns a stream of parallel words into one serial bit stream using a tree of registered 2:1 multiplexers instead of one long shift register. A word of `WORD_W` bits, where `WORD_W` is a power of two, passes through `log2(WORD_W)` mux layers. Each layer halves the width: 16 to 8, 8 to 4, 4 to 2, then 2 to 1. Each layer updates half as often as the layer after it. In silicon each layer has its own divide-by-two clock, and the last layer drives a bit on both edges of the fastest clock. In this RTL, one clock period of `clk_i` is one serial bit time, and a divider counter issues per-layer enables and selects.

Every mux output is a flip-flop. The layers are offset from one another by one bit time, so that each layer samples its upstream register only after that register has settled. The word is permuted by bit-reversal as it is captured, so that the even-first, odd-second order of every layer sends the word out most significant bit first. `load_o` marks the cycle in which `word_i` is taken. The upstream source holds its word valid for that cycle.

Top module: `tree_serializer`

## Requirements
- R1: While `rst_ni` is low, `ser_o` is 0.
- R2: `load_o` is high in the first cycle after reset is released, and then in exactly one cycle out of every `WORD_W`. `word_i` is captured at the rising edge that ends a cycle in which `load_o` is high.
- R3: A captured word leaves most significant bit first. If the word is captured at edge k (edges counted from 0 at the first edge after reset), bit `WORD_W-1-p` is on `ser_o` in the cycle after edge k+`log2(WORD_W)`+p, for p from 0 to `WORD_W-1`.
- R4: The first bit of the first word after reset appears exactly `log2(WORD_W)` edges after its capture edge, which is `log2(WORD_W)`+1 register stages in all.
- R5: Consecutive words leave back to back, with no gap, repeat or overlap. Every mux layer holds its value in cycles in which its enable is low.
- R6: After reset is released, `ser_o` stays 0 until the first bit of the first captured word arrives.
- R7: A reset applied part-way through a word discards that word, restarts the load cadence and emits no partial word afterwards.
- R8: The value of `word_i` in cycles where `load_o` is low has no effect on `ser_o`.
- R9: The block works for any power-of-two `WORD_W` of at least 2, with the layer count derived from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-time clock; one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset; aligns all dividers |
| word_i | input | WORD_W | Parallel word, taken in the cycle where `load_o` is high |
| load_o | output | 1 | High in the cycle whose closing edge captures `word_i` |
| ser_o | output | 1 | Serial data, most significant bit first |

## Verification
The bench builds two instances side by side. One has `WORD_W` = 16, the full four-layer tree. The other has `WORD_W` = 4, a two-layer tree, which a counting pattern sweeps through all 16 possible words many times. On the 16-bit instance, walking-one, walking-zero, hashed and counting words place every bit position at every serial slot and exercise both select phases of each layer. Bits on `ser_o` are reassembled into words and compared with the words the bench captured. Between load cycles the bench drives unrelated values on `word_i`. One reset is applied part-way through a word, which reaches the realignment case.

// File: rtl/tree_ser_pkg.sv
package tree_ser_pkg;

  // Reverse the low nbits bits of v.
  function automatic int unsigned bit_rev(input int unsigned v, input int unsigned nbits);
    int unsigned r;
    r = 0;
    for (int unsigned b = 0; b < nbits; b++) begin
      r = (r << 1) | ((v >> b) & 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/tree_ser_div.sv
module tree_ser_div #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              load_o,
  output logic [STAGES-1:0] en_o,
  output logic [STAGES-1:0] sel_o
);

  // Binary count == cascade of divide-by-two toggles; bit j runs at 1/2^(j+1) rate.
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign load_o = (cnt_q == '0);

  // Layer j (output width 2^j) lags the capture register by STAGES-j bit times.
  for (genvar j = 0; j < STAGES; j++) begin : g_phase
    localparam logic [STAGES-1:0] DLY  = STAGES'(STAGES - j);
    localparam logic [STAGES-1:0] MASK = STAGES'((1 << j) - 1);
    logic [STAGES-1:0] rel;
    assign rel      = cnt_q - DLY;
    assign en_o[j]  = ((rel & MASK) == '0);
    assign sel_o[j] = rel[j];
  end

  // R2
  load_no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

endmodule

// File: rtl/tree_ser_capture.sv
module tree_ser_capture
  import tree_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] tree_o
);

  // Serial slot p leaves from tree leaf bit_rev(p); slot 0 carries the MSB.
  logic [WORD_W-1:0] perm;

  for (genvar p = 0; p < WORD_W; p++) begin : g_perm
    localparam int unsigned LEAF = bit_rev(p, STAGES);
    assign perm[LEAF] = word_i[WORD_W-1-p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tree_o <= '0;
    else if (load_i) tree_o <= perm;
  end

  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(tree_o));

endmodule

// File: rtl/tree_ser_stage.sv
module tree_ser_stage #(
  parameter int unsigned OUT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sel_i,
  input  logic [2*OUT_W-1:0] d_i,
  output logic [OUT_W-1:0]   q_o
);

  logic [OUT_W-1:0] mux;

  // Even input in the first half-period, odd input in the second.
  for (genvar i = 0; i < OUT_W; i++) begin : g_mux
    assign mux[i] = sel_i ? d_i[2*i+1] : d_i[2*i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= mux;
  end

  // R5
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

endmodule

// File: rtl/tree_serializer.sv
module tree_serializer #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              load_o,
  output logic              ser_o
);

  localparam int unsigned STAGES    = $clog2(WORD_W);
  // Packed triangle: level j (width 2^j) sits at bits [2^(j+1)-2 : 2^j-1].
  localparam int unsigned TREE_BITS = 2 * WORD_W - 1;

  logic [STAGES-1:0]    en;
  logic [STAGES-1:0]    sel;
  logic [TREE_BITS-1:0] tree;

  tree_ser_div #(
    .STAGES (STAGES)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_o (load_o),
    .en_o   (en),
    .sel_o  (sel)
  );

  tree_ser_capture #(
    .WORD_W (WORD_W),
    .STAGES (STAGES)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_o),
    .word_i (word_i),
    .tree_o (tree[TREE_BITS-1:WORD_W-1])
  );

  for (genvar j = 0; j < STAGES; j++) begin : g_layer
    localparam int unsigned OUT_W = 1 << j;
    tree_ser_stage #(
      .OUT_W (OUT_W)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[j]),
      .sel_i  (sel[j]),
      .d_i    (tree[4*OUT_W-2:2*OUT_W-1]),
      .q_o    (tree[2*OUT_W-2:OUT_W-1])
    );
  end

  assign ser_o = tree[0];

  // R4
  load_to_first_layer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> en[STAGES-1]);

endmodule

// File: tb/tree_serializer_tb.sv
module tree_serializer_tb;

  localparam int W_A = 16;
  localparam int S_A = 4;
  localparam int W_B = 4;
  localparam int S_B = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word_a = '0;
  logic [3:0]  word_b = '0;
  logic        load_a, load_b, ser_a, ser_b;

  int checks = 0;
  int fails  = 0;
  int e      = 0;
  int r7_until = 0;

  logic [15:0] hist_a [0:2047];
  logic [3:0]  hist_b [0:2047];
  logic [15:0] asm_a = '0;
  logic [3:0]  asm_b = '0;

  always #4 clk = ~clk;

  tree_serializer #(.WORD_W(W_A)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .word_i (word_a), .load_o (load_a), .ser_o (ser_a)
  );

  tree_serializer #(.WORD_W(W_B)) u_dut_w4 (
    .clk_i (clk), .rst_ni (rst_n), .word_i (word_b), .load_o (load_b), .ser_o (ser_b)
  );

  function automatic logic [15:0] pat(input int kind, input int f, input int w);
    logic [31:0] v;
    case (kind)
      0:       v = 32'd1 << (f % w);
      1:       v = ~(32'd1 << (f % w));
      2:       v = (f * 40503 + 23100) ^ (f << 7) ^ (f >> 2);
      default: v = f;
    endcase
    return 16'(v & ((32'd1 << w) - 1));
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string req);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, expv, e);
    end
  endtask

  // Outputs as they stand after edge n.
  task automatic check_out(input int n);
    int m;
    string tag;
    m = n - S_A;
    if (m < 0) chk(16'(ser_a), 16'd0, (n < r7_until) ? "R7" : "R6");
    else begin
      tag = (m == 0) ? "R4" : "R3";
      if (n < r7_until) tag = "R7";
      chk(16'(ser_a), 16'(hist_a[m / W_A][W_A - 1 - m % W_A]), tag);
      asm_a = {asm_a[14:0], ser_a};
      if (m % W_A == W_A - 1) chk(asm_a, hist_a[m / W_A], "R5");
    end
    m = n - S_B;
    if (m < 0) chk(16'(ser_b), 16'd0, "R6 R9");
    else begin
      chk(16'(ser_b), 16'(hist_b[m / W_B][W_B - 1 - m % W_B]), "R3 R9");
      asm_b = {asm_b[2:0], ser_b};
      if (m % W_B == W_B - 1) chk(16'(asm_b), 16'(hist_b[m / W_B]), "R5 R9");
    end
  endtask

  // Inputs for edge e; off-load cycles carry unrelated values (R8).
  task automatic drive(input int kind);
    logic [15:0] pa, pb;
    chk(16'(load_a), 16'(e % W_A == 0), "R2");
    chk(16'(load_b), 16'(e % W_B == 0), "R2 R9");
    pa = pat(kind, e / W_A, W_A);
    pb = pat(kind, e / W_B, W_B);
    if (e % W_A == 0) begin
      hist_a[e / W_A] = pa;
      word_a = pa;
    end else word_a = ~pa ^ 16'(e * 7919);
    if (e % W_B == 0) begin
      hist_b[e / W_B] = pb[3:0];
      word_b = pb[3:0];
    end else word_b = ~pb[3:0] ^ 4'(e);
    e++;
  endtask

  task automatic step(input int kind);
    @(negedge clk);
    check_out(e - 1);
    drive(kind);
  endtask

  task automatic do_reset(input int kind);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(16'(ser_a), 16'd0, "R1");
      chk(16'(ser_b), 16'd0, "R1");
    end
    rst_n = 1'b1;
    e = 0;
    drive(kind);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset(0);
    repeat (16 * 40) step(0);
    do_reset(1);
    repeat (16 * 40) step(1);
    do_reset(2);
    repeat (16 * 20 + 7) step(2);
    // R7: reset lands mid-word
    r7_until = 2 * W_A + S_A;
    do_reset(3);
    repeat (16 * 300) step(3);
    r7_until = 0;
    do_reset(2);
    repeat (16 * 200) step(2);
    finish_run();
  end

endmodule